// File: doc/BRIEF.md
# Two-Tap Self-Synchronizing Word Scrambler Pair

This block holds a transmit scrambler and a receive descrambler for a wide parallel data word. The word is treated as a slice of a serial stream, bit 0 first in time. Each line bit is the data bit XORed with two earlier line bits. These sit a near and a far tap distance back in the stream, 39 and 58 bits by default (polynomial 1 + x^39 + x^58). The whole word is unrolled, so one word is handled per clock. The descrambler XORs each received bit with the received bits at the same two distances. It therefore depends only on what arrived on the line, and it falls into step by itself once one word has passed. There is no training or handshake. The scrambling breaks up long unfavourable runs in random-like traffic.

Because the descrambler reuses received bits as its taps, a single corrupted line bit is seen three times: once where it lands, and again at each tap distance later. This can push errors into the following word. Each side has a bypass input that carries the word through unchanged while the tap history still takes in the bits that were carried. Both histories clear to zero on reset, so the first received word after reset is only correct if the far end also started from zero.

Top module: `sc2_scrambler_pair`

## Requirements
- R1: For each valid, non-bypass transmit word, line bit at serial position i (word bit 0 earliest) equals data[i] ^ line[i-TAP_NEAR] ^ line[i-TAP_FAR]. Taps reach back into earlier valid words when i is smaller than the distance.
- R2: For each valid, non-bypass received word, output bit i equals rx_line[i] ^ rx_line[i-TAP_NEAR] ^ rx_line[i-TAP_FAR]. Only received bits are used.
- R3: With tx_line fed back into rx_line, the receive output equals the transmit data of the word before.
- R4: Whatever the receive history holds, every valid received word that follows at least one earlier valid received word is descrambled correctly.
- R5: A single flipped line bit at serial position p gives output errors at exactly p, p+TAP_NEAR and p+TAP_FAR, and at no other positions.
- R6: When bypass is high with valid, the output word equals the input word. The tap history still takes in that word for later words.
- R7: Outputs are registered with one cycle of latency, and each output valid equals the input valid of the cycle before. When valid is low, the output word and the history hold.
- R8: After reset both valids are low, both output words are zero and both histories are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transmit data word present |
| tx_bypass | input | 1 | Carry transmit word unscrambled |
| tx_data | input | WORD_W | Transmit data word, bit 0 first in time |
| tx_line_valid | output | 1 | Line word present |
| tx_line | output | WORD_W | Scrambled line word |
| rx_valid | input | 1 | Received line word present |
| rx_bypass | input | 1 | Carry received word undescrambled |
| rx_line | input | WORD_W | Received line word, bit 0 first in time |
| rx_data_valid | output | 1 | Descrambled word present |
| rx_data | output | WORD_W | Descrambled data word |

## Verification
On every cycle the assertions check the valid timing, that outputs and history hold while idle, and that bypass words pass through unchanged. They also check that each scrambled word descrambles back to its data with a second, non-recursive form of the equation. Self-alignment from an unknown far-end history, the exact error positions after a flipped line bit, and the full transmit-to-receive loop depend on long sequences of words. Only the bench scenarios can show them, using a bit-serial reference model and directed error injection.

// File: rtl/sc2_pkg.sv
package sc2_pkg;
    localparam int SC2_WORD_W   = 80;
    localparam int SC2_TAP_NEAR = 39;
    localparam int SC2_TAP_FAR  = 58;
endpackage

// File: rtl/sc2_tap_fetch.sv
// Gathers, for every bit of a word, the stream bits lying a near and a far
// distance behind it, reaching into the previous word where needed.
module sc2_tap_fetch #(
    parameter int WORD_W   = 80,
    parameter int TAP_NEAR = 39,
    parameter int TAP_FAR  = 58
) (
    input  logic [WORD_W-1:0] cur_word,
    input  logic [WORD_W-1:0] prev_word,
    output logic [WORD_W-1:0] near_bits,
    output logic [WORD_W-1:0] far_bits
);
    localparam int SPAN_W = 2 * WORD_W;

    logic [SPAN_W-1:0] span;
    assign span = {cur_word, prev_word};

    for (genvar j = 0; j < WORD_W; j++) begin : g_bit
        assign near_bits[j] = span[WORD_W + j - TAP_NEAR];
        assign far_bits[j]  = span[WORD_W + j - TAP_FAR];
    end
endmodule

// File: rtl/sc2_scrambler.sv
// Transmit side: recursive two-tap scrambler unrolled over one word.
module sc2_scrambler #(
    parameter int WORD_W   = 80,
    parameter int TAP_NEAR = 39,
    parameter int TAP_FAR  = 58
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_bypass,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_line
);
    localparam int SPAN_W = 2 * WORD_W;

    // The line register doubles as the tap history.
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] hist;
    } scr_state_t;

    scr_state_t st_d, st_q;

    always_comb begin
        logic [SPAN_W-1:0] span;
        span = {{WORD_W{1'b0}}, st_q.hist};
        for (int j = 0; j < WORD_W; j++) begin
            if (in_bypass) begin
                span[WORD_W + j] = in_data[j];
            end else begin
                span[WORD_W + j] = in_data[j]
                                 ^ span[WORD_W + j - TAP_NEAR]
                                 ^ span[WORD_W + j - TAP_FAR];
            end
        end
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.hist = span[SPAN_W-1:WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_line  = st_q.hist;

    // Non-recursive inverse used only to cross-check the recursive path.
    function automatic logic [WORD_W-1:0] undo_word(input logic [WORD_W-1:0] line,
                                                    input logic [WORD_W-1:0] prev);
        logic [SPAN_W-1:0] s;
        logic [WORD_W-1:0] r;
        s = {line, prev};
        for (int j = 0; j < WORD_W; j++) begin
            r[j] = line[j] ^ s[WORD_W + j - TAP_NEAR] ^ s[WORD_W + j - TAP_FAR];
        end
        return r;
    endfunction

    a_r3_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_bypass) |=> (undo_word(out_line, $past(st_q.hist)) == $past(in_data)));

    a_r6_tx_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bypass) |=> (out_line == $past(in_data)));

    a_r7_tx_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r7_tx_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_line)));
endmodule

// File: rtl/sc2_descrambler.sv
// Receive side: feed-forward descrambler using received bits only.
module sc2_descrambler #(
    parameter int WORD_W   = 80,
    parameter int TAP_NEAR = 39,
    parameter int TAP_FAR  = 58
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_bypass,
    input  logic [WORD_W-1:0] in_line,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] hist;
        logic [WORD_W-1:0] data;
    } dsc_state_t;

    dsc_state_t        st_d, st_q;
    logic [WORD_W-1:0] near_bits;
    logic [WORD_W-1:0] far_bits;

    sc2_tap_fetch #(
        .WORD_W  (WORD_W),
        .TAP_NEAR(TAP_NEAR),
        .TAP_FAR (TAP_FAR)
    ) u_taps (
        .cur_word (in_line),
        .prev_word(st_q.hist),
        .near_bits(near_bits),
        .far_bits (far_bits)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.hist = in_line;
            st_d.data = in_bypass ? in_line : (in_line ^ near_bits ^ far_bits);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;

    a_r6_rx_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bypass) |=> (out_data == $past(in_line)));

    a_r7_rx_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r7_rx_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data) && $stable(st_q.hist)));
endmodule

// File: rtl/sc2_scrambler_pair.sv
module sc2_scrambler_pair
    import sc2_pkg::*;
#(
    parameter int WORD_W   = SC2_WORD_W,
    parameter int TAP_NEAR = SC2_TAP_NEAR,
    parameter int TAP_FAR  = SC2_TAP_FAR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic              tx_bypass,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_line_valid,
    output logic [WORD_W-1:0] tx_line,
    input  logic              rx_valid,
    input  logic              rx_bypass,
    input  logic [WORD_W-1:0] rx_line,
    output logic              rx_data_valid,
    output logic [WORD_W-1:0] rx_data
);
    // Both taps must stay within one word so a single word of history suffices.
    if (TAP_NEAR < 1 || TAP_NEAR >= TAP_FAR || TAP_FAR > WORD_W) begin : g_cfg_bad
        $error("sc2_scrambler_pair: taps must satisfy 1 <= near < far <= word width");
    end

    sc2_scrambler #(
        .WORD_W  (WORD_W),
        .TAP_NEAR(TAP_NEAR),
        .TAP_FAR (TAP_FAR)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (tx_valid),
        .in_bypass(tx_bypass),
        .in_data  (tx_data),
        .out_valid(tx_line_valid),
        .out_line (tx_line)
    );

    sc2_descrambler #(
        .WORD_W  (WORD_W),
        .TAP_NEAR(TAP_NEAR),
        .TAP_FAR (TAP_FAR)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rx_valid),
        .in_bypass(rx_bypass),
        .in_line  (rx_line),
        .out_valid(rx_data_valid),
        .out_data (rx_data)
    );
endmodule

// File: tb/sc2_scrambler_pair_tb.sv
module sc2_scrambler_pair_tb;
    import sc2_pkg::*;

    localparam int W  = SC2_WORD_W;
    localparam int TN = SC2_TAP_NEAR;
    localparam int TF = SC2_TAP_FAR;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_valid = 1'b0, tx_bypass = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic         tx_line_valid;
    logic [W-1:0] tx_line;
    logic         rx_valid = 1'b0, rx_bypass = 1'b0;
    logic [W-1:0] rx_line = '0;
    logic         rx_data_valid;
    logic [W-1:0] rx_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [TF:1] m_tx_sr;
    logic [TF:1] m_rx_sr;

    always #10 clk = ~clk;

    sc2_scrambler_pair u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_bypass(tx_bypass), .tx_data(tx_data),
        .tx_line_valid(tx_line_valid), .tx_line(tx_line),
        .rx_valid(rx_valid), .rx_bypass(rx_bypass), .rx_line(rx_line),
        .rx_data_valid(rx_data_valid), .rx_data(rx_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Bit-serial reference: shift register of past line bits, newest at [1].
    task automatic model_tx(input logic [W-1:0] d, input logic byp,
                            inout logic [TF:1] sr, output logic [W-1:0] line);
        for (int i = 0; i < W; i++) begin
            logic b;
            b = byp ? d[i] : (d[i] ^ sr[TN] ^ sr[TF]);
            line[i] = b;
            sr = {sr[TF-1:1], b};
        end
    endtask

    task automatic model_rx(input logic [W-1:0] r, input logic byp,
                            inout logic [TF:1] sr, output logic [W-1:0] d);
        for (int i = 0; i < W; i++) begin
            d[i] = byp ? r[i] : (r[i] ^ sr[TN] ^ sr[TF]);
            sr = {sr[TF-1:1], r[i]};
        end
    endtask

    function automatic logic [W-1:0] rnd_word();
        logic [W-1:0] w;
        for (int k = 0; k < W; k += 32) begin
            w = {w[W-1:0] << 32} | W'($urandom);
        end
        return w;
    endfunction

    task automatic cyc(input logic tv, input logic tb, input logic [W-1:0] td,
                       input logic rv, input logic rb, input logic [W-1:0] rl);
        logic [W-1:0] etx, erx;
        etx = tx_line;
        erx = rx_data;
        if (tv) model_tx(td, tb, m_tx_sr, etx);
        if (rv) model_rx(rl, rb, m_rx_sr, erx);
        tx_valid = tv; tx_bypass = tb; tx_data = td;
        rx_valid = rv; rx_bypass = rb; rx_line = rl;
        @(negedge clk);
        chk(tx_line_valid == tv, "R7 tx valid latency", W'(tx_line_valid), W'(tv));
        chk(rx_data_valid == rv, "R7 rx valid latency", W'(rx_data_valid), W'(rv));
        chk(tx_line == etx, !tv ? "R7 tx hold" : (tb ? "R6 tx bypass" : "R1 scramble"),
            tx_line, etx);
        chk(rx_data == erx, !rv ? "R7 rx hold" : (rb ? "R6 rx bypass" : "R2 descramble"),
            rx_data, erx);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tx_valid = 1'b0; tx_bypass = 1'b0; tx_data = '0;
        rx_valid = 1'b0; rx_bypass = 1'b0; rx_line = '0;
        repeat (3) @(negedge clk);
        m_tx_sr = '0;
        m_rx_sr = '0;
        rst_n = 1'b1;
        chk(!tx_line_valid && !rx_data_valid, "R8 reset valids low",
            W'({tx_line_valid, rx_data_valid}), '0);
        chk(tx_line == '0, "R8 reset tx line zero", tx_line, '0);
        chk(rx_data == '0, "R8 reset rx data zero", rx_data, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d_prev, d, l, mask0, mask1;
        logic [TF:1]  far_sr;
        void'($urandom(32'd20240607));
        @(negedge clk);
        do_reset();

        // R8/R1: zero history on first word; R6: bypass word feeds history
        cyc(1'b1, 1'b0, {W{1'b1}}, 1'b0, 1'b0, '0);
        cyc(1'b1, 1'b1, rnd_word(), 1'b1, 1'b1, rnd_word());
        cyc(1'b1, 1'b0, '0, 1'b1, 1'b0, rnd_word());
        cyc(1'b0, 1'b0, rnd_word(), 1'b0, 1'b0, rnd_word());

        // Random mixed traffic on both sides
        for (int n = 0; n < 400; n++) begin
            cyc(($urandom % 5) != 0, ($urandom % 6) == 0, rnd_word(),
                ($urandom % 5) != 0, ($urandom % 6) == 0, rnd_word());
        end

        // R3: loop tx_line back into the receiver
        do_reset();
        d_prev = rnd_word();
        cyc(1'b1, 1'b0, d_prev, 1'b0, 1'b0, '0);
        for (int k = 0; k < 30; k++) begin
            d = rnd_word();
            cyc(1'b1, 1'b0, d, 1'b1, 1'b0, tx_line);
            chk(rx_data == d_prev, "R3 loopback round trip", rx_data, d_prev);
            d_prev = d;
        end

        // R4: far end starts from an unknown history
        do_reset();
        far_sr = {rnd_word(), rnd_word()};
        for (int k = 0; k < 6; k++) begin
            d = rnd_word();
            model_tx(d, 1'b0, far_sr, l);
            cyc(1'b0, 1'b0, '0, 1'b1, 1'b0, l);
            if (k >= 1) chk(rx_data == d, "R4 self alignment", rx_data, d);
        end

        // R5: single flipped line bit at two positions
        for (int e = 0; e < 2; e++) begin
            int p;
            p = (e == 0) ? 30 : W - 1;
            mask0 = '0; mask1 = '0;
            mask0[p] = 1'b1;
            if (p + TN < W) mask0[p + TN] = 1'b1; else mask1[p + TN - W] = 1'b1;
            if (p + TF < W) mask0[p + TF] = 1'b1; else mask1[p + TF - W] = 1'b1;
            for (int k = 0; k < 4; k++) begin
                d = rnd_word();
                model_tx(d, 1'b0, far_sr, l);
                if (k == 1) l[p] = ~l[p];
                cyc(1'b0, 1'b0, '0, 1'b1, 1'b0, l);
                if (k == 1) chk((rx_data ^ d) == mask0, "R5 errors in hit word", rx_data ^ d, mask0);
                if (k == 2) chk((rx_data ^ d) == mask1, "R5 errors in next word", rx_data ^ d, mask1);
                if (k == 3) chk(rx_data == d, "R5 recovered", rx_data, d);
            end
        end

        // R6: receive bypass with idle gaps
        for (int k = 0; k < 5; k++) begin
            l = rnd_word();
            cyc(1'b0, 1'b0, '0, 1'b1, 1'b1, l);
            chk(rx_data == l, "R6 rx pass through", rx_data, l);
            cyc(1'b0, 1'b0, '0, 1'b0, 1'b1, rnd_word());
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule